// File: doc/BRIEF.md
# Multicycle Instruction Sequencing Controller

This block is the finite-state sequencer of a multicycle load/store processor. Each instruction runs through a shared fetch cycle and a shared decode cycle. It then follows an opcode-specific path of execute, memory and writeback cycles, and returns to fetch. In every cycle it drives the select, write-enable and ALU-operation lines of a datapath that holds the PC, the instruction register, the memory data register, the A/B operand latches and ALUOut. The datapath itself and the ALU function decoding are outside this block.

The outputs are a Moore function of the current state. The opcode is looked at only on the clock edge that ends the decode cycle. During decode the controller always sets up the ALU to form PC plus the shifted immediate, so a branch target is ready one cycle before the instruction type is known. Reset is asynchronous and active low. Its release passes through a synchronizer, and all control lines stay low until that release has propagated.

Top module: `mcc_controller`

## Requirements
- R1: While `rst_n` is low, every output is 0, including the cycle in which reset is first asserted. After `rst_n` rises, all outputs stay 0 until the second rising clock edge. The fetch settings appear from that edge on.
- R2: A fetch cycle asserts `pc_wr`, `mem_rd` and `ir_wr`, with `addr_sel_data`=0, `alu_a_sel`=0, `alu_b_sel`=01 (constant four), `alu_op`=00 (add) and `pc_src`=00 (ALU result). Every other output is 0, and the cycle after it is always a decode cycle.
- R3: A decode cycle drives `alu_a_sel`=0, `alu_b_sel`=11 (shifted immediate) and `alu_op`=00 for every opcode. All other outputs are 0.
- R4: A load (opcode 100011) takes 5 cycles. Cycle 3 sets `alu_a_sel`=1, `alu_b_sel`=10 and `alu_op`=00. Cycle 4 sets `addr_sel_data`=1 and `mem_rd`=1. Cycle 5 sets `rf_wr`=1, `wb_from_mem`=1 and `rf_dst_rd`=0.
- R5: A store (opcode 101011) takes 4 cycles. Cycle 3 is the same as for a load. Cycle 4 sets `addr_sel_data`=1 and `mem_wr`=1.
- R6: A register-register operation (opcode 000000) takes 4 cycles. Cycle 3 sets `alu_a_sel`=1, `alu_b_sel`=00 and `alu_op`=10 (function field). Cycle 4 sets `rf_wr`=1, `rf_dst_rd`=1 and `wb_from_mem`=0.
- R7: A branch-if-equal (opcode 000100) takes 3 cycles. Cycle 3 sets `alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=01 (subtract), `pc_wr_cond`=1 and `pc_src`=01 (ALUOut), while `pc_wr` stays 0.
- R8: A jump (opcode 000010) takes 3 cycles. Cycle 3 sets `pc_wr`=1 and `pc_src`=10 (jump target), and every other output is 0.
- R9: Any other opcode present at the end of decode sends the controller straight back to fetch, so that instruction takes 2 cycles.
- R10: After the decode cycle, changes on `opcode` have no effect on the remaining cycles of the instruction.
- R11: `mem_rd` and `mem_wr` are never high in the same cycle. Any output that a state does not name is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized |
| opcode | input | 6 | Opcode field from the instruction register |
| pc_wr | output | 1 | Unconditional PC write enable |
| pc_wr_cond | output | 1 | PC write enable qualified by the ALU zero flag |
| addr_sel_data | output | 1 | Memory address from ALUOut (1) or PC (0) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| wb_from_mem | output | 1 | Register write data from MDR (1) or ALUOut (0) |
| ir_wr | output | 1 | Instruction register write enable |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALUOut, 10 jump target |
| alu_op | output | 2 | 00 add, 01 subtract, 10 function field |
| alu_a_sel | output | 1 | ALU A operand: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B operand: 00 B, 01 four, 10 immediate, 11 shifted immediate |
| rf_wr | output | 1 | Register file write enable |
| rf_dst_rd | output | 1 | Destination register from rd (1) or rt (0) |

## Verification
Because the outputs are decoded from the state alone, a wrong state shows up at the ports in the very cycle it is entered. It appears as a control word that differs from what that instruction should have in that cycle, for example a missing writeback or a premature fetch. The bench compares all sixteen output bits with a per-cycle reference on every clock, so a misrouted transition is caught at most one cycle after the faulty edge. This includes a wrong instruction length, a store taking the load path, or a late opcode change taking effect. A fault in the reset synchronizer shows up as fetch controls one cycle early or one cycle late.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;

  localparam logic [1:0] SRCB_REG    = 2'b00;
  localparam logic [1:0] SRCB_FOUR   = 2'b01;
  localparam logic [1:0] SRCB_IMM    = 2'b10;
  localparam logic [1:0] SRCB_IMM_SH = 2'b11;

  localparam logic [1:0] PCS_ALU    = 2'b00;
  localparam logic [1:0] PCS_ALUOUT = 2'b01;
  localparam logic [1:0] PCS_JUMP   = 2'b10;

  localparam logic [1:0] AOP_ADD   = 2'b00;
  localparam logic [1:0] AOP_SUB   = 2'b01;
  localparam logic [1:0] AOP_FUNCT = 2'b10;

  typedef enum logic [3:0] {
    ST_FETCH    = 4'd0,
    ST_DECODE   = 4'd1,
    ST_ADDR_LD  = 4'd2,
    ST_ADDR_ST  = 4'd3,
    ST_MEM_RD   = 4'd4,
    ST_LOAD_WB  = 4'd5,
    ST_MEM_WR   = 4'd6,
    ST_R_EXEC   = 4'd7,
    ST_R_DONE   = 4'd8,
    ST_BRANCH   = 4'd9,
    ST_JUMP     = 4'd10
  } seq_state_t;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       addr_sel_data;
    logic       mem_rd;
    logic       mem_wr;
    logic       wb_from_mem;
    logic       ir_wr;
    logic [1:0] pc_src;
    logic [1:0] alu_op;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic       rf_wr;
    logic       rf_dst_rd;
  } ctrl_word_t;

endpackage

// File: rtl/mcc_reset_sync.sv
module mcc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  generate
    if (STAGES <= 1) begin : g_single
      logic flop_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flop_q <= 1'b0;
        else        flop_q <= 1'b1;
      end
      assign rst_sync_n = flop_q;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
      assign rst_sync_n = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
  import mcc_pkg::*;
(
  input  seq_state_t       state_q,
  input  logic [OPC_W-1:0] opcode,
  output seq_state_t       state_d
);

  seq_state_t decode_target;

  always_comb begin
    case (opcode)
      OPC_LOAD:  decode_target = ST_ADDR_LD;
      OPC_STORE: decode_target = ST_ADDR_ST;
      OPC_RTYPE: decode_target = ST_R_EXEC;
      OPC_BEQ:   decode_target = ST_BRANCH;
      OPC_JUMP:  decode_target = ST_JUMP;
      default:   decode_target = ST_FETCH;
    endcase
  end

  always_comb begin
    case (state_q)
      ST_FETCH:   state_d = ST_DECODE;
      ST_DECODE:  state_d = decode_target;
      ST_ADDR_LD: state_d = ST_MEM_RD;
      ST_ADDR_ST: state_d = ST_MEM_WR;
      ST_MEM_RD:  state_d = ST_LOAD_WB;
      ST_R_EXEC:  state_d = ST_R_DONE;
      default:    state_d = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mcc_state_reg.sv
module mcc_state_reg
  import mcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_sync_n,
  input  logic       advance_en,
  input  seq_state_t state_d,
  output seq_state_t state_q
);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_FETCH;
    end else if (advance_en) begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/mcc_ctrl_decode.sv
module mcc_ctrl_decode
  import mcc_pkg::*;
(
  input  seq_state_t state_q,
  input  logic       out_en,
  output ctrl_word_t ctrl
);

  ctrl_word_t raw;

  always_comb begin
    raw = '0;
    case (state_q)
      ST_FETCH: begin
        raw.mem_rd    = 1'b1;
        raw.ir_wr     = 1'b1;
        raw.pc_wr     = 1'b1;
        raw.pc_src    = PCS_ALU;
        raw.alu_a_sel = 1'b0;
        raw.alu_b_sel = SRCB_FOUR;
        raw.alu_op    = AOP_ADD;
      end
      ST_DECODE: begin
        raw.alu_a_sel = 1'b0;
        raw.alu_b_sel = SRCB_IMM_SH;
        raw.alu_op    = AOP_ADD;
      end
      ST_ADDR_LD, ST_ADDR_ST: begin
        raw.alu_a_sel = 1'b1;
        raw.alu_b_sel = SRCB_IMM;
        raw.alu_op    = AOP_ADD;
      end
      ST_MEM_RD: begin
        raw.addr_sel_data = 1'b1;
        raw.mem_rd        = 1'b1;
      end
      ST_LOAD_WB: begin
        raw.rf_wr       = 1'b1;
        raw.wb_from_mem = 1'b1;
        raw.rf_dst_rd   = 1'b0;
      end
      ST_MEM_WR: begin
        raw.addr_sel_data = 1'b1;
        raw.mem_wr        = 1'b1;
      end
      ST_R_EXEC: begin
        raw.alu_a_sel = 1'b1;
        raw.alu_b_sel = SRCB_REG;
        raw.alu_op    = AOP_FUNCT;
      end
      ST_R_DONE: begin
        raw.rf_wr       = 1'b1;
        raw.rf_dst_rd   = 1'b1;
        raw.wb_from_mem = 1'b0;
      end
      ST_BRANCH: begin
        raw.alu_a_sel  = 1'b1;
        raw.alu_b_sel  = SRCB_REG;
        raw.alu_op     = AOP_SUB;
        raw.pc_wr_cond = 1'b1;
        raw.pc_src     = PCS_ALUOUT;
      end
      ST_JUMP: begin
        raw.pc_wr  = 1'b1;
        raw.pc_src = PCS_JUMP;
      end
      default: raw = '0;
    endcase
  end

  assign ctrl = out_en ? raw : '0;

endmodule

// File: rtl/mcc_controller.sv
module mcc_controller
  import mcc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  output logic             pc_wr,
  output logic             pc_wr_cond,
  output logic             addr_sel_data,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             wb_from_mem,
  output logic             ir_wr,
  output logic [1:0]       pc_src,
  output logic [1:0]       alu_op,
  output logic             alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic             rf_wr,
  output logic             rf_dst_rd
);

  logic       rst_sync_n;
  seq_state_t state_q;
  seq_state_t state_d;
  ctrl_word_t ctrl;

  mcc_reset_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mcc_next_state u_next (
    .state_q (state_q),
    .opcode  (opcode),
    .state_d (state_d)
  );

  mcc_state_reg u_state (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .advance_en (rst_sync_n),
    .state_d    (state_d),
    .state_q    (state_q)
  );

  mcc_ctrl_decode u_decode (
    .state_q (state_q),
    .out_en  (rst_sync_n),
    .ctrl    (ctrl)
  );

  assign pc_wr         = ctrl.pc_wr;
  assign pc_wr_cond    = ctrl.pc_wr_cond;
  assign addr_sel_data = ctrl.addr_sel_data;
  assign mem_rd        = ctrl.mem_rd;
  assign mem_wr        = ctrl.mem_wr;
  assign wb_from_mem   = ctrl.wb_from_mem;
  assign ir_wr         = ctrl.ir_wr;
  assign pc_src        = ctrl.pc_src;
  assign alu_op        = ctrl.alu_op;
  assign alu_a_sel     = ctrl.alu_a_sel;
  assign alu_b_sel     = ctrl.alu_b_sel;
  assign rf_wr         = ctrl.rf_wr;
  assign rf_dst_rd     = ctrl.rf_dst_rd;

endmodule

// File: rtl/mcc_controller_chk.sv
module mcc_controller_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pc_wr,
  input logic       pc_wr_cond,
  input logic       addr_sel_data,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       wb_from_mem,
  input logic       ir_wr,
  input logic [1:0] pc_src,
  input logic [1:0] alu_op,
  input logic       alu_a_sel,
  input logic [1:0] alu_b_sel,
  input logic       rf_wr,
  input logic       rf_dst_rd
);

  logic any_out;
  assign any_out = pc_wr | pc_wr_cond | addr_sel_data | mem_rd | mem_wr |
                   wb_from_mem | ir_wr | rf_wr | rf_dst_rd | alu_a_sel |
                   (|pc_src) | (|alu_op) | (|alu_b_sel);

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> !any_out);

  a_r1_quiet_on_release: assert property (@(posedge clk)
    $rose(rst_n) |-> !any_out);

  a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (!rst_n)
    ir_wr |=> (alu_b_sel == 2'b11 && !ir_wr && !pc_wr));

  a_r3_decode_no_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_b_sel == 2'b11) |-> (!alu_a_sel && alu_op == 2'b00 && !rf_wr &&
                              !mem_wr && !mem_rd && !pc_wr && !pc_wr_cond));

  a_r4_load_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && addr_sel_data) |=> (rf_wr && wb_from_mem && !rf_dst_rd));

  a_r5_store_ends: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> ir_wr);

  a_r6_rtype_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == 2'b10) |=> (rf_wr && rf_dst_rd && !wb_from_mem));

  a_r7_branch_cond_only: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_cond |-> (!pc_wr && pc_src == 2'b01));

  a_r7_branch_ends: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_cond |=> ir_wr);

  a_r8_jump_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr && pc_src == 2'b10) |=> ir_wr);

  a_r11_mem_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

endmodule

bind mcc_controller mcc_controller_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pc_wr         (pc_wr),
  .pc_wr_cond    (pc_wr_cond),
  .addr_sel_data (addr_sel_data),
  .mem_rd        (mem_rd),
  .mem_wr        (mem_wr),
  .wb_from_mem   (wb_from_mem),
  .ir_wr         (ir_wr),
  .pc_src        (pc_src),
  .alu_op        (alu_op),
  .alu_a_sel     (alu_a_sel),
  .alu_b_sel     (alu_b_sel),
  .rf_wr         (rf_wr),
  .rf_dst_rd     (rf_dst_rd)
);

// File: tb/tb_mcc_controller.sv
`timescale 1ns/1ps
module tb_mcc_controller;

  logic       clk;
  logic       rst_n;
  logic [5:0] opcode;
  logic       pc_wr, pc_wr_cond, addr_sel_data, mem_rd, mem_wr, wb_from_mem;
  logic       ir_wr, alu_a_sel, rf_wr, rf_dst_rd;
  logic [1:0] pc_src, alu_op, alu_b_sel;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  mcc_controller dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .addr_sel_data(addr_sel_data),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .wb_from_mem(wb_from_mem),
    .ir_wr(ir_wr), .pc_src(pc_src), .alu_op(alu_op), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .rf_wr(rf_wr), .rf_dst_rd(rf_dst_rd)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // packs {pcw, pcc, iord, mrd, mwr, m2r, irw, pcsrc, aop, sa, sb, rw, rd}
  function automatic logic [15:0] w(bit pcw, bit pcc, bit iord, bit mrd,
                                    bit mwr, bit m2r, bit irw,
                                    logic [1:0] ps, logic [1:0] aop, bit sa,
                                    logic [1:0] sb, bit rw, bit rd);
    return {pcw, pcc, iord, mrd, mwr, m2r, irw, ps, aop, sa, sb, rw, rd};
  endfunction

  function automatic logic [15:0] observed();
    return {pc_wr, pc_wr_cond, addr_sel_data, mem_rd, mem_wr, wb_from_mem,
            ir_wr, pc_src, alu_op, alu_a_sel, alu_b_sel, rf_wr, rf_dst_rd};
  endfunction

  localparam logic [15:0] W_ZERO   = 16'h0;
  localparam logic [15:0] W_FETCH  = {1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,2'b00,2'b00,1'b0,2'b01,1'b0,1'b0};
  localparam logic [15:0] W_DECODE = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,2'b11,1'b0,1'b0};

  task automatic check(logic [15:0] exp, string req);
    checks++;
    if (observed() !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, observed(), exp);
    end
  endtask

  // Reference: per-cycle expected control words for one instruction
  task automatic build(logic [5:0] op, ref logic [15:0] q[$], ref string tags[$]);
    q.delete(); tags.delete();
    q.push_back(W_FETCH);  tags.push_back("R2");
    q.push_back(W_DECODE); tags.push_back("R3");
    case (op)
      6'b100011: begin
        q.push_back(w(0,0,0,0,0,0,0,2'b00,2'b00,1,2'b10,0,0)); tags.push_back("R4");
        q.push_back(w(0,0,1,1,0,0,0,2'b00,2'b00,0,2'b00,0,0)); tags.push_back("R4");
        q.push_back(w(0,0,0,0,0,1,0,2'b00,2'b00,0,2'b00,1,0)); tags.push_back("R4");
      end
      6'b101011: begin
        q.push_back(w(0,0,0,0,0,0,0,2'b00,2'b00,1,2'b10,0,0)); tags.push_back("R5");
        q.push_back(w(0,0,1,0,1,0,0,2'b00,2'b00,0,2'b00,0,0)); tags.push_back("R5");
      end
      6'b000000: begin
        q.push_back(w(0,0,0,0,0,0,0,2'b00,2'b10,1,2'b00,0,0)); tags.push_back("R6");
        q.push_back(w(0,0,0,0,0,0,0,2'b00,2'b00,0,2'b00,1,1)); tags.push_back("R6");
      end
      6'b000100: begin
        q.push_back(w(0,1,0,0,0,0,0,2'b01,2'b01,1,2'b00,0,0)); tags.push_back("R7");
      end
      6'b000010: begin
        q.push_back(w(1,0,0,0,0,0,0,2'b10,2'b00,0,2'b00,0,0)); tags.push_back("R8");
      end
      default: ;
    endcase
  endtask

  // Runs one instruction; scramble alters opcode after decode (R10)
  task automatic run_instr(logic [5:0] op, bit scramble);
    logic [15:0] q[$];
    string tags[$];
    build(op, q, tags);
    for (int k = 0; k < q.size(); k++) begin
      @(negedge clk);
      if (k >= 2 && scramble)
        opcode = (op == 6'b000010) ? 6'b100011 : 6'b000010;
      else
        opcode = op;
      check(q[k], scramble && k >= 2 ? {tags[k], "/R10"} : tags[k]);
    end
    if (q.size() == 2) begin
      // R9: next cycle must already be a fetch
      @(negedge clk);
      opcode = 6'b000000;
      check(W_FETCH, "R9");
      @(negedge clk);
      check(W_DECODE, "R9");
      @(negedge clk);
      check(w(0,0,0,0,0,0,0,2'b00,2'b10,1,2'b00,0,0), "R9");
      @(negedge clk);
      check(w(0,0,0,0,0,0,0,2'b00,2'b00,0,2'b00,1,1), "R9");
    end
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(W_ZERO, "R1 sync window");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n  = 1'b0;
    opcode = 6'b000000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(W_ZERO, "R1 in reset");
    release_reset();

    run_instr(6'b100011, 0);
    run_instr(6'b101011, 0);
    run_instr(6'b000000, 0);
    run_instr(6'b000100, 0);
    run_instr(6'b000010, 0);
    run_instr(6'b111111, 0);
    run_instr(6'b000001, 0);
    run_instr(6'b100011, 1);
    run_instr(6'b101011, 1);
    run_instr(6'b000000, 1);
    run_instr(6'b000010, 1);
    run_instr(6'b000100, 1);

    // R1: asynchronous reset in the middle of a load
    @(negedge clk); opcode = 6'b100011; check(W_FETCH, "R2");
    @(negedge clk); check(W_DECODE, "R3");
    @(negedge clk); check(w(0,0,0,0,0,0,0,2'b00,2'b00,1,2'b10,0,0), "R4");
    #1 rst_n = 1'b0;
    #0.5 check(W_ZERO, "R1 async assert");
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(W_ZERO, "R1 held");
    release_reset();

    for (int i = 0; i < 40; i++) begin
      case (i % 6)
        0: run_instr(6'b100011, i[0]);
        1: run_instr(6'b000100, i[0]);
        2: run_instr(6'b101011, i[0]);
        3: run_instr(6'b010101, 0);
        4: run_instr(6'b000010, i[0]);
        default: run_instr(6'b000000, i[0]);
      endcase
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule